// File: doc/BRIEF.md
# H-Bridge Chopper Current Limiter and Short Classifier

This block is the timing core of an H-bridge protection path. On every enabled clock tick it samples comparator flags from the current-sense cells. The flags are a per-output current-limit flag, a per-output short-threshold flag (low-side sense) and a per-output high-side overcurrent flag. From these it decides when all four power stages must be switched off. A brief overcurrent that lasts through a blanking interval starts a chopper cycle. The stages go off for a fixed interval and then come back on without any intervention.

The blanking interval does a second job. While the limit is being tolerated, a short-threshold crossing is taken as a short to supply on that output. A high-side overcurrent that persists through a filter interval is taken as a short to ground. When a high-side report and a low-side report arrive close together, the block classifies the fault as a short across the load. Each kind of short latches the stages off until the enable or disable pins re-arm the bridge.

All intervals are parameters counted in ticks. The `tick` input is a clock enable that sets the time base, so nothing advances on cycles without a tick.

Top module: `hbridge_chop_guard`

## Requirements
- R1: When any bit of `lim_flag` is sampled high on `TBLANK` consecutive ticks, `chop_active` rises after the `TBLANK`-th of those ticks. If every bit of `lim_flag` is sampled low before that tick, the bridge returns to normal run and no chop starts.
- R2: A chop keeps `chop_active` high for exactly `TOFF` ticks (or `TBLANK` ticks if that is larger), with `lim_flag` and `sc_flag` ignored. Normal run then resumes.
- R3: The blanking window is made of three cases: the tick on which the limit first appears in run, every tick spent blanking, and every tick while a fault is latched. `sc_flag[x]` sampled high on any tick in this window latches a fault (`fault_latched`=1) and sets `scb_flt[x]`, where bit x is output x. Outside the window, `sc_flag` has no effect.
- R4: `hs_oc[x]` sampled high on `TFILT` consecutive ticks latches a fault and sets `scg_flt[x]`. A shorter burst has no effect. One persistent burst gives one report.
- R5: A high-side report and a low-side report that fall on the same tick, or no more than `TCOINC` ticks apart, set `scol_flt` and clear `scb_flt` and `scg_flt`. While `scol_flt` is set, the per-output bits stay clear.
- R6: A latched fault persists until a clear event and nothing else ends it. A clear event is `en` sampled rising while `dis` is low, or `dis` sampled falling while `en` is high (edges judged between successive ticks). A clear event ends the fault and zeroes all fault bits and `ilim_stat`. Any reports on that tick are discarded.
- R7: `ilim_stat` is set on every chop start and holds until a clear event.
- R8: `stages_off` is high whenever `en` is low, `dis` is high, a chop is running or a fault is latched, and is low otherwise.
- R9: On clock cycles with `tick` low, no state, counter or flag changes.
- R10: After reset the block is in normal run, with every fault bit, `ilim_stat`, `chop_active` and `fault_latched` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base enable; all sampling and counting happen on ticks |
| en | input | 1 | Bridge enable, active high |
| dis | input | 1 | Bridge disable, active high |
| lim_flag | input | NOUT | Current above the chopper limit, per output |
| sc_flag | input | NOUT | Low-side current above the short threshold, per output |
| hs_oc | input | NOUT | High-side overcurrent, per output |
| stages_off | output | 1 | Command that switches all output stages off |
| chop_active | output | 1 | Chopper off interval running |
| fault_latched | output | 1 | A short has latched the stages off |
| scb_flt | output | NOUT | Latched short to supply, bit x = output x |
| scg_flt | output | NOUT | Latched short to ground, bit x = output x |
| scol_flt | output | 1 | Latched short across the load |
| ilim_stat | output | 1 | Current-limit status, set on each chop |

## Verification
A wrong blanking count shows as a chop that starts a tick early or late, or as a short to supply missed near the window edge. Either appears on `chop_active` or `scb_flt` in the tick where the error occurs. A wrong state in the filter or coincidence counters shows up on the next short report, as a bit set in `scg_flt` or `scol_flt` that should not be there. A latch that leaks shows as `stages_off` falling without a clear edge on `en` or `dis`. A reference model stepped on every tick compares all outputs one nanosecond after each clock edge, so any such error is caught in the cycle it first reaches a port.

// File: rtl/chopg_pkg.sv
package chopg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BLANK = 2'd1,
    ST_CHOP  = 2'd2,
    ST_FAULT = 2'd3
  } chop_st_t;
endpackage

// File: rtl/chopg_hs_filter.sv
module chopg_hs_filter #(
  parameter int TFILT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oc,
  output logic rep
);
  localparam int CW = $clog2(TFILT + 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    rep = tick && oc && (cnt == CW'(TFILT - 1));
    if (!oc)
      cnt_n = '0;
    else if (cnt == CW'(TFILT))
      cnt_n = cnt;
    else
      cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (tick)
      cnt <= cnt_n;
  end

  // one burst gives one report
  assert_single_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rep |=> !rep);
endmodule

// File: rtl/chopg_coinc.sv
module chopg_coinc #(
  parameter int TCOINC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic hs_any,
  input  logic ls_any,
  output logic hit
);
  localparam int AW = $clog2(TCOINC + 1);

  logic [AW-1:0] hage, lage, hage_n, lage_n;

  always_comb begin
    hit = (hs_any && ls_any) ||
          (hs_any && (lage < AW'(TCOINC))) ||
          (ls_any && (hage < AW'(TCOINC)));
    if (clr) begin
      hage_n = AW'(TCOINC);
      lage_n = AW'(TCOINC);
    end else begin
      hage_n = hs_any ? '0 : ((hage == AW'(TCOINC)) ? hage : hage + 1'b1);
      lage_n = ls_any ? '0 : ((lage == AW'(TCOINC)) ? lage : lage + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hage <= AW'(TCOINC);
      lage <= AW'(TCOINC);
    end else if (tick) begin
      hage <= hage_n;
      lage <= lage_n;
    end
  end

  // a fresh report restarts its own age
  assert_age_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hs_any && !clr) |=> (hage == '0));
endmodule

// File: rtl/chopg_fsm.sv
module chopg_fsm
  import chopg_pkg::*;
#(
  parameter int NOUT   = 2,
  parameter int TBLANK = 13,
  parameter int TOFF   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clr,
  input  logic [NOUT-1:0] lim,
  input  logic [NOUT-1:0] sc,
  input  logic            hs_ev,
  output chop_st_t        st,
  output logic [NOUT-1:0] ls_rep,
  output logic            chop_enter
);
  localparam int TOFF_E = (TOFF > TBLANK) ? TOFF : TBLANK;
  localparam int CW     = $clog2(TOFF_E + 1);

  chop_st_t      st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          lim_any, win, fault_go;

  always_comb begin
    lim_any  = |lim;
    win      = (st == ST_BLANK) || (st == ST_FAULT) ||
               ((st == ST_RUN) && lim_any);
    ls_rep   = (tick && !clr && win) ? sc : '0;
    fault_go = (|ls_rep) || hs_ev;
    st_n     = st;
    cnt_n    = cnt;
    if (clr && (st == ST_FAULT)) begin
      st_n = ST_RUN;
    end else if (fault_go) begin
      st_n = ST_FAULT;
    end else begin
      case (st)
        ST_RUN: begin
          if (lim_any) begin
            st_n  = ST_BLANK;
            cnt_n = CW'(1);
          end
        end
        ST_BLANK: begin
          if (!lim_any) begin
            st_n = ST_RUN;
          end else if (cnt == CW'(TBLANK - 1)) begin
            st_n  = ST_CHOP;
            cnt_n = CW'(1);
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_CHOP: begin
          if (cnt == CW'(TOFF_E))
            st_n = ST_RUN;
          else
            cnt_n = cnt + 1'b1;
        end
        default: st_n = st;
      endcase
    end
    chop_enter = tick && (st == ST_BLANK) && (st_n == ST_CHOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else if (tick) begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  // a chop is only ever entered from the blanking window
  assert_chop_from_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CHOP) && ($past(st) != ST_CHOP)) |-> ($past(st) == ST_BLANK));

  // a latched fault holds until a clear event
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FAULT) && !(tick && clr)) |=> (st == ST_FAULT));
endmodule

// File: rtl/hbridge_chop_guard.sv
module hbridge_chop_guard
  import chopg_pkg::*;
#(
  parameter int NOUT   = 2,
  parameter int TBLANK = 13,
  parameter int TOFF   = 16,
  parameter int TFILT  = 2,
  parameter int TCOINC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en,
  input  logic            dis,
  input  logic [NOUT-1:0] lim_flag,
  input  logic [NOUT-1:0] sc_flag,
  input  logic [NOUT-1:0] hs_oc,
  output logic            stages_off,
  output logic            chop_active,
  output logic            fault_latched,
  output logic [NOUT-1:0] scb_flt,
  output logic [NOUT-1:0] scg_flt,
  output logic            scol_flt,
  output logic            ilim_stat
);
  logic [1:0]      rst_sync;
  logic            rst_s_n;
  logic            en_q, dis_q, clr;
  logic [NOUT-1:0] hs_rep, hs_ev_vec, ls_rep;
  logic            hs_any, ls_any, hit, chop_enter;
  chop_st_t        st;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  // enable / disable edge tracking between ticks
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q  <= 1'b0;
      dis_q <= 1'b1;
    end else if (tick) begin
      en_q  <= en;
      dis_q <= dis;
    end
  end

  always_comb begin
    clr       = tick && ((en && !en_q && !dis) || (!dis && dis_q && en));
    hs_ev_vec = clr ? '0 : hs_rep;
    hs_any    = |hs_ev_vec;
    ls_any    = |ls_rep;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_hsf
    chopg_hs_filter #(.TFILT(TFILT)) u_hsf (
      .clk   (clk),
      .rst_n (rst_s_n),
      .tick  (tick),
      .oc    (hs_oc[g]),
      .rep   (hs_rep[g])
    );
  end

  chopg_fsm #(.NOUT(NOUT), .TBLANK(TBLANK), .TOFF(TOFF)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick       (tick),
    .clr        (clr),
    .lim        (lim_flag),
    .sc         (sc_flag),
    .hs_ev      (hs_any),
    .st         (st),
    .ls_rep     (ls_rep),
    .chop_enter (chop_enter)
  );

  chopg_coinc #(.TCOINC(TCOINC)) u_coinc (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (tick),
    .clr    (clr),
    .hs_any (hs_any),
    .ls_any (ls_any),
    .hit    (hit)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      scb_flt   <= '0;
      scg_flt   <= '0;
      scol_flt  <= 1'b0;
      ilim_stat <= 1'b0;
    end else if (tick) begin
      if (clr) begin
        scb_flt   <= '0;
        scg_flt   <= '0;
        scol_flt  <= 1'b0;
        ilim_stat <= 1'b0;
      end else begin
        if (hit) begin
          scol_flt <= 1'b1;
          scb_flt  <= '0;
          scg_flt  <= '0;
        end else if (!scol_flt) begin
          scb_flt <= scb_flt | ls_rep;
          scg_flt <= scg_flt | hs_ev_vec;
        end
        if (chop_enter)
          ilim_stat <= 1'b1;
      end
    end
  end

  assign chop_active   = (st == ST_CHOP);
  assign fault_latched = (st == ST_FAULT);
  assign stages_off    = !en || dis || chop_active || fault_latched;

  // the load-short flag excludes the per-output flags
  assert_scol_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    scol_flt |-> ((scb_flt == '0) && (scg_flt == '0)));

  // any stored short goes with a latched-off bridge
  assert_flags_need_latch_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((|scb_flt) || (|scg_flt) || scol_flt) |-> fault_latched);

  // status only rises together with a chop
  assert_ilim_with_chop_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ilim_stat) |-> chop_active);

  for (genvar g = 0; g < NOUT; g++) begin : g_chk
    // a short to ground on output g needs that output's high-side flag
    assert_scg_source_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
      $rose(scg_flt[g]) |-> $past(hs_oc[g]));
  end
endmodule

// File: tb/tb_hbridge_chop_guard.sv
`timescale 1ns/1ps
module tb_hbridge_chop_guard;
  localparam int NOUT = 2;
  localparam int TB   = 13;
  localparam int TO   = 16;
  localparam int TF   = 2;
  localparam int TC   = 2;
  localparam int TOE  = (TO > TB) ? TO : TB;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, en, dis;
  logic [NOUT-1:0] lim_flag, sc_flag, hs_oc;
  logic stages_off, chop_active, fault_latched, scol_flt, ilim_stat;
  logic [NOUT-1:0] scb_flt, scg_flt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbridge_chop_guard #(.NOUT(NOUT), .TBLANK(TB), .TOFF(TO), .TFILT(TF), .TCOINC(TC)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .dis(dis),
    .lim_flag(lim_flag), .sc_flag(sc_flag), .hs_oc(hs_oc),
    .stages_off(stages_off), .chop_active(chop_active), .fault_latched(fault_latched),
    .scb_flt(scb_flt), .scg_flt(scg_flt), .scol_flt(scol_flt), .ilim_stat(ilim_stat)
  );

  // reference model state: 0 run, 1 blank, 2 chop, 3 fault
  int m_st, m_cnt, m_hage, m_lage;
  int m_hcnt [NOUT];
  bit m_enq, m_disq, m_scol, m_ilim;
  bit [NOUT-1:0] m_scb, m_scg;

  function automatic bit m_off(bit e, bit d);
    return !e || d || (m_st == 2) || (m_st == 3);
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_hage = TC; m_lage = TC;
    for (int i = 0; i < NOUT; i++) m_hcnt[i] = 0;
    m_enq = 0; m_disq = 1; m_scol = 0; m_ilim = 0; m_scb = '0; m_scg = '0;
  endtask

  task automatic model_tick(bit e, bit d, bit [NOUT-1:0] lim, bit [NOUT-1:0] sc,
                            bit [NOUT-1:0] hs);
    bit clr, win, hany, lany, hit, go;
    bit [NOUT-1:0] hrep, lrep;
    clr = (e && !m_enq && !d) || (!d && m_disq && e);
    m_enq = e; m_disq = d;
    for (int i = 0; i < NOUT; i++) begin
      hrep[i] = hs[i] && (m_hcnt[i] == TF - 1);
      if (!hs[i]) m_hcnt[i] = 0;
      else if (m_hcnt[i] < TF) m_hcnt[i]++;
    end
    win  = (m_st == 1) || (m_st == 3) || ((m_st == 0) && (|lim));
    lrep = (win && !clr) ? sc : '0;
    if (clr) hrep = '0;
    hany = |hrep; lany = |lrep;
    hit  = (hany && lany) || (hany && m_lage < TC) || (lany && m_hage < TC);
    go   = hany || lany;
    if (clr) begin
      m_hage = TC; m_lage = TC;
      m_scb = '0; m_scg = '0; m_scol = 0; m_ilim = 0;
    end else begin
      m_hage = hany ? 0 : ((m_hage < TC) ? m_hage + 1 : TC);
      m_lage = lany ? 0 : ((m_lage < TC) ? m_lage + 1 : TC);
      if (hit) begin
        m_scol = 1; m_scb = '0; m_scg = '0;
      end else if (!m_scol) begin
        m_scb |= lrep; m_scg |= hrep;
      end
    end
    if (clr && m_st == 3) m_st = 0;
    else if (go) m_st = 3;
    else begin
      case (m_st)
        0: if (|lim) begin m_st = 1; m_cnt = 1; end
        1: begin
          if (!(|lim)) m_st = 0;
          else if (m_cnt == TB - 1) begin
            m_st = 2; m_cnt = 1;
            if (!clr) m_ilim = 1;
          end else m_cnt++;
        end
        2: if (m_cnt == TOE) m_st = 0; else m_cnt++;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R8 stages_off", stages_off, m_off(en, dis));
    chk("R1 R2 chop_active", chop_active, m_st == 2);
    chk("R6 fault_latched", fault_latched, m_st == 3);
    chk("R3 scb_flt", scb_flt, m_scb);
    chk("R4 scg_flt", scg_flt, m_scg);
    chk("R5 scol_flt", scol_flt, m_scol);
    chk("R7 ilim_stat", ilim_stat, m_ilim);
  endtask

  task automatic step(bit tk, bit e, bit d, bit [NOUT-1:0] lim, bit [NOUT-1:0] sc,
                      bit [NOUT-1:0] hs);
    @(negedge clk);
    tick = tk; en = e; dis = d; lim_flag = lim; sc_flag = sc; hs_oc = hs;
    @(posedge clk);
    if (tk) model_tick(e, d, lim, sc, hs);
    #1;
    cmp_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, '0, '0, '0);
  endtask

  task automatic do_clear();
    step(1, 0, 0, '0, '0, '0);
    step(1, 1, 0, '0, '0, '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; en = 0; dis = 0;
    lim_flag = '0; sc_flag = '0; hs_oc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 chop_active", chop_active, 0);
    chk("R10 fault_latched", fault_latched, 0);
    chk("R10 flags", {scb_flt, scg_flt, scol_flt, ilim_stat}, 0);
    chk("R8 stages_off with en low", stages_off, 1);

    idle(3);
    chk("R8 stages_off running", stages_off, 0);

    // R1: limit shorter than the blanking time gives no chop
    for (int i = 0; i < TB - 1; i++) step(1, 1, 0, 2'b01, '0, '0);
    chk("R1 no chop before blanking ends", chop_active, 0);
    step(1, 1, 0, '0, '0, '0);
    chk("R1 limit dropped returns to run", chop_active, 0);

    // R1/R2/R7: full blanking then fixed off time
    for (int i = 0; i < TB; i++) step(1, 1, 0, 2'b10, '0, '0);
    chk("R1 chop after blanking", chop_active, 1);
    chk("R7 status set by chop", ilim_stat, 1);
    for (int i = 0; i < TOE - 1; i++) step(1, 1, 0, 2'b11, 2'b11, '0);
    chk("R2 still chopping, flags ignored", chop_active, 1);
    chk("R2 short flag ignored in chop", scb_flt, 0);
    step(1, 1, 0, '0, '0, '0);
    chk("R2 resumes after off time", chop_active, 0);

    // R9: no tick, no progress
    for (int i = 0; i < 40; i++) step(0, 1, 0, 2'b01, 2'b01, 2'b11);
    chk("R9 no blanking without tick", chop_active, 0);
    chk("R9 no fault without tick", fault_latched, 0);

    // R6/R7: clear via disable falling edge
    step(1, 1, 1, '0, '0, '0);
    step(1, 1, 0, '0, '0, '0);
    chk("R7 status cleared", ilim_stat, 0);

    // R3: short to supply on the first blanking tick, output 1
    step(1, 1, 0, 2'b10, 2'b10, '0);
    chk("R3 short to supply bit1", scb_flt, 2'b10);
    chk("R3 fault latched", fault_latched, 1);
    chk("R8 stages off when latched", stages_off, 1);
    idle(20);
    step(1, 1, 1, '0, '0, '0);
    chk("R6 raising dis does not clear", fault_latched, 1);
    step(1, 1, 1, '0, '0, '0);
    do_clear();
    chk("R6 enable rising clears", fault_latched, 0);
    chk("R6 flags cleared", scb_flt, 0);

    // R3: sc outside the window ignored
    step(1, 1, 0, '0, 2'b01, '0);
    chk("R3 sc ignored in run", fault_latched, 0);

    // R4: short burst then full filter
    for (int i = 0; i < TF - 1; i++) step(1, 1, 0, '0, '0, 2'b01);
    step(1, 1, 0, '0, '0, '0);
    chk("R4 short burst ignored", fault_latched, 0);
    for (int i = 0; i < TF; i++) step(1, 1, 0, '0, '0, 2'b01);
    chk("R4 short to ground bit0", scg_flt, 2'b01);
    idle(5);
    do_clear();

    // R5: coincident reports become a load short
    for (int i = 0; i < TF; i++) step(1, 1, 0, '0, '0, 2'b10);
    step(1, 1, 0, '0, 2'b01, '0);
    chk("R5 load short flagged", scol_flt, 1);
    chk("R5 per-output bits cleared", {scb_flt, scg_flt}, 0);
    do_clear();

    // R5: reports too far apart stay separate
    for (int i = 0; i < TF; i++) step(1, 1, 0, '0, '0, 2'b01);
    idle(TC);
    step(1, 1, 0, '0, 2'b10, '0);
    chk("R5 late report not a load short", scol_flt, 0);
    chk("R5 late report kept per output", scb_flt, 2'b10);
    do_clear();

    // random phase
    begin
      int unsigned seed;
      bit e, d, tk;
      bit [NOUT-1:0] lim, sc, hs;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      e = 1; d = 0; lim = '0; hs = '0;
      for (int n = 0; n < 20000; n++) begin
        tk = ($urandom % 4) != 0;
        if ($urandom % 40 == 0) e = !e;
        if ($urandom % 50 == 0) d = !d;
        for (int i = 0; i < NOUT; i++) begin
          if ($urandom % 6 == 0) lim[i] = !lim[i];
          if (hs[i]) begin if ($urandom % 3 == 0) hs[i] = 0; end
          else if ($urandom % 120 == 0) hs[i] = 1;
          sc[i] = ($urandom % 70 == 0);
        end
        step(tk, e, d, lim, sc, hs);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule